// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage In-Order Pipeline

This block holds the valid bits, program counters and instruction words of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and keeps exceptions precise. The execute or memory datapath raises a fault together with a small cause code. The controller then lets every instruction older than the faulting one finish its memory access and its register write. It blocks every side effect of the faulting instruction and discards all younger instructions. It also records the faulting address, the raw instruction word and the cause, and it redirects fetch to a fixed handler address.

The surrounding datapath reads the execute and memory slots from the controller. It performs a memory access only when `mem_go` is high and writes the register file only when `rf_we` is high. Software clears the captured record by pulsing `trap_ack`. Until then, later faults still flush the pipeline and redirect fetch, but they leave the record unchanged.

Top module: `precise_trap_ctrl`

## Requirements
- R1: When a fault is taken in execute, the older instruction in memory still sees `mem_go` high in that cycle, and it commits through `rf_we` one cycle later with its own PC.
- R2: An instruction faulting in execute never enters the memory stage and never appears on the `rf_we`/`rf_pc` commit port.
- R3: On a taken fault, the instructions in decode and fetch are discarded. In the following cycle decode and execute are empty, and none of the discarded PCs is ever committed.
- R4: In the cycle after a taken fault, `fetch_pc` equals `HANDLER_VEC` (default 0x100). Fetch then proceeds sequentially in steps of 4.
- R5: A taken fault with no record pending loads `epc` with the faulting PC, `einsn` with its instruction word and `ecause` with its cause code, and sets `trap_pending`. All of these are visible in the next cycle.
- R6: When memory and execute both fault in the same cycle, only the memory-stage instruction is recorded, because it is the older one. Its `mem_go` is low in that cycle and it is never committed.
- R7: While `trap_pending` is high, `epc`, `einsn` and `ecause` hold their values, even across further faults. Such faults still flush and redirect. A `trap_ack` pulse clears `trap_pending` on the next edge.
- R8: A fault input raised while its stage holds no valid instruction has no effect: fetch continues sequentially and no record is made.
- R9: During reset, `fetch_pc` equals `RESET_VEC` (default 0), and all stages are empty, so `rf_we`, `ex_valid` and `mem_valid` are low and `trap_pending` is low.
- R10: Without faults, the instruction fetched at a PC in one cycle commits four cycles later. Commits arrive in program order, and each carries the same instruction word that was fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_insn | input | INSN_W | Instruction word read at `fetch_pc` |
| ex_fault | input | 1 | Fault raised by the execute stage |
| ex_cause | input | CAUSE_W | Cause code of the execute fault |
| mem_fault | input | 1 | Fault raised by the memory stage |
| mem_cause | input | CAUSE_W | Cause code of the memory fault |
| trap_ack | input | 1 | Clears the pending exception record |
| fetch_pc | output | PC_W | Address being fetched |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_pc | output | PC_W | PC in execute |
| ex_insn | output | INSN_W | Instruction word in execute |
| mem_valid | output | 1 | Memory slot holds an instruction |
| mem_pc | output | PC_W | PC in memory |
| mem_go | output | 1 | Memory access of the memory slot may proceed |
| rf_we | output | 1 | Writeback commits this cycle |
| rf_pc | output | PC_W | PC of the committing instruction |
| rf_insn | output | INSN_W | Word of the committing instruction |
| trap_pending | output | 1 | An exception record is held |
| epc | output | PC_W | Captured faulting PC |
| einsn | output | INSN_W | Captured faulting instruction word |
| ecause | output | CAUSE_W | Captured cause code |

## Verification
The bound checker examines every cycle for several properties. It checks the redirect to the handler vector, that decode and execute are empty after a fault, that the faulting instruction stays out of memory and writeback, and that the older memory instruction commits. It also checks that a memory-stage fault blocks writeback, that the record is held while pending, and that a fault on an empty slot leaves fetch sequential. Other behaviour shows only in the bench's scenarios: the order and content of the whole commit stream, the exact word and cause captured, oldest-first priority when both stages fault together, a fault ignored while a record is pending, and the clearing by acknowledge.

// File: rtl/trap_pkg.sv
package trap_pkg;
    parameter int unsigned PC_W    = 32;
    parameter int unsigned INSN_W  = 32;
    parameter int unsigned CAUSE_W = 4;
    parameter int unsigned PC_STEP = 4;

    // pipeline slots after fetch, youngest first
    localparam int unsigned NSTAGE = 4;
    localparam int unsigned ST_ID  = 0;
    localparam int unsigned ST_EX  = 1;
    localparam int unsigned ST_MEM = 2;
    localparam int unsigned ST_WB  = 3;

    typedef struct packed {
        logic              valid;
        logic [PC_W-1:0]   pc;
        logic [INSN_W-1:0] insn;
    } slot_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EX   = 2'd1,
        SRC_MEM  = 2'd2
    } trap_src_e;

    function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
        return pc + PC_W'(PC_STEP);
    endfunction
endpackage

// File: rtl/trap_fetch.sv
module trap_fetch
    import trap_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_VEC   = '0,
    parameter logic [PC_W-1:0] HANDLER_VEC = PC_W'(32'h100)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            redirect,
    output logic [PC_W-1:0] pc_q
);
    always_ff @(posedge clk) begin
        if (rst)           pc_q <= RESET_VEC;
        else if (redirect) pc_q <= HANDLER_VEC;
        else               pc_q <= seq_pc(pc_q);
    end
endmodule

// File: rtl/trap_stage_regs.sv
module trap_stage_regs
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_t             fetch_slot,
    input  logic [NSTAGE-1:0] squash,
    output slot_t             id_o,
    output slot_t             ex_o,
    output slot_t             mem_o,
    output slot_t             wb_o
);
    slot_t stage_q [NSTAGE];

    for (genvar i = 0; i < NSTAGE; i++) begin : g_st
        slot_t src;
        slot_t q;
        if (i == 0) begin : g_head
            assign src = fetch_slot;
        end else begin : g_body
            assign src = stage_q[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                q <= src;
                if (squash[i]) q.valid <= 1'b0;
            end
        end
        assign stage_q[i] = q;
    end

    assign id_o  = stage_q[ST_ID];
    assign ex_o  = stage_q[ST_EX];
    assign mem_o = stage_q[ST_MEM];
    assign wb_o  = stage_q[ST_WB];
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  slot_t              ex_slot,
    input  slot_t              mem_slot,
    input  logic               ex_fault,
    input  logic               mem_fault,
    input  logic [CAUSE_W-1:0] ex_cause,
    input  logic [CAUSE_W-1:0] mem_cause,
    output logic               take,
    output slot_t              trap_slot,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [NSTAGE-1:0]  squash
);
    trap_src_e src;
    int unsigned kill_upto;

    always_comb begin
        src        = SRC_NONE;
        trap_slot  = '0;
        trap_cause = '0;
        kill_upto  = 0;
        // oldest faulting instruction wins
        if (mem_slot.valid && mem_fault) begin
            src        = SRC_MEM;
            trap_slot  = mem_slot;
            trap_cause = mem_cause;
            kill_upto  = ST_MEM + 1;
        end else if (ex_slot.valid && ex_fault) begin
            src        = SRC_EX;
            trap_slot  = ex_slot;
            trap_cause = ex_cause;
            kill_upto  = ST_EX + 1;
        end
        take = (src != SRC_NONE);
        for (int i = 0; i < NSTAGE; i++) begin
            squash[i] = take && (i <= kill_upto);
        end
    end
endmodule

// File: rtl/trap_capture.sv
module trap_capture
    import trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  slot_t              trap_slot,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic               ack,
    output logic               pending,
    output logic [PC_W-1:0]    epc_q,
    output logic [INSN_W-1:0]  einsn_q,
    output logic [CAUSE_W-1:0] ecause_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            epc_q    <= '0;
            einsn_q  <= '0;
            ecause_q <= '0;
        end else if (take && !pending) begin
            pending  <= 1'b1;
            epc_q    <= trap_slot.pc;
            einsn_q  <= trap_slot.insn;
            ecause_q <= trap_cause;
        end else if (ack) begin
            pending  <= 1'b0;
        end
    end
endmodule

// File: rtl/precise_trap_ctrl.sv
module precise_trap_ctrl
    import trap_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_VEC   = '0,
    parameter logic [PC_W-1:0] HANDLER_VEC = PC_W'(32'h100)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSN_W-1:0]  fetch_insn,
    input  logic               ex_fault,
    input  logic [CAUSE_W-1:0] ex_cause,
    input  logic               mem_fault,
    input  logic [CAUSE_W-1:0] mem_cause,
    input  logic               trap_ack,
    output logic [PC_W-1:0]    fetch_pc,
    output logic               ex_valid,
    output logic [PC_W-1:0]    ex_pc,
    output logic [INSN_W-1:0]  ex_insn,
    output logic               mem_valid,
    output logic [PC_W-1:0]    mem_pc,
    output logic               mem_go,
    output logic               rf_we,
    output logic [PC_W-1:0]    rf_pc,
    output logic [INSN_W-1:0]  rf_insn,
    output logic               trap_pending,
    output logic [PC_W-1:0]    epc,
    output logic [INSN_W-1:0]  einsn,
    output logic [CAUSE_W-1:0] ecause
);
    slot_t fetch_slot, id_s, ex_s, mem_s, wb_s, trap_slot;
    logic [NSTAGE-1:0]  squash;
    logic [CAUSE_W-1:0] trap_cause;
    logic take;
    logic id_valid;

    trap_fetch #(.RESET_VEC(RESET_VEC), .HANDLER_VEC(HANDLER_VEC)) u_fetch (
        .clk(clk), .rst(rst), .redirect(take), .pc_q(fetch_pc)
    );

    assign fetch_slot = '{valid: 1'b1, pc: fetch_pc, insn: fetch_insn};

    trap_stage_regs u_pipe (
        .clk(clk), .rst(rst), .fetch_slot(fetch_slot), .squash(squash),
        .id_o(id_s), .ex_o(ex_s), .mem_o(mem_s), .wb_o(wb_s)
    );

    trap_arbiter u_arb (
        .ex_slot(ex_s), .mem_slot(mem_s),
        .ex_fault(ex_fault), .mem_fault(mem_fault),
        .ex_cause(ex_cause), .mem_cause(mem_cause),
        .take(take), .trap_slot(trap_slot), .trap_cause(trap_cause),
        .squash(squash)
    );

    trap_capture u_cap (
        .clk(clk), .rst(rst), .take(take), .trap_slot(trap_slot),
        .trap_cause(trap_cause), .ack(trap_ack), .pending(trap_pending),
        .epc_q(epc), .einsn_q(einsn), .ecause_q(ecause)
    );

    assign id_valid  = id_s.valid;
    assign ex_valid  = ex_s.valid;
    assign ex_pc     = ex_s.pc;
    assign ex_insn   = ex_s.insn;
    assign mem_valid = mem_s.valid;
    assign mem_pc    = mem_s.pc;
    assign mem_go    = mem_s.valid && !mem_fault;
    assign rf_we     = wb_s.valid;
    assign rf_pc     = wb_s.pc;
    assign rf_insn   = wb_s.insn;
endmodule

// File: rtl/trap_ctrl_checker.sv
module trap_ctrl_checker
    import trap_pkg::*;
#(
    parameter logic [PC_W-1:0] HANDLER_VEC = PC_W'(32'h100)
) (
    input logic            clk,
    input logic            rst,
    input logic            ex_fault,
    input logic            ex_valid,
    input logic [PC_W-1:0] ex_pc,
    input logic            mem_fault,
    input logic            mem_valid,
    input logic [PC_W-1:0] mem_pc,
    input logic            id_valid,
    input logic            rf_we,
    input logic [PC_W-1:0] rf_pc,
    input logic [PC_W-1:0] fetch_pc,
    input logic            trap_pending,
    input logic [PC_W-1:0] epc
);
    logic ex_hit, mem_hit;
    assign ex_hit  = ex_fault && ex_valid;
    assign mem_hit = mem_fault && mem_valid;

    a_r1_older_commits: assert property (@(posedge clk) disable iff (rst)
        (ex_hit && !mem_hit && mem_valid) |=> (rf_we && rf_pc == $past(mem_pc)));

    a_r2_faulter_blocked: assert property (@(posedge clk) disable iff (rst)
        ex_hit |=> !(mem_valid && mem_pc == $past(ex_pc)));

    a_r3_younger_gone: assert property (@(posedge clk) disable iff (rst)
        (ex_hit || mem_hit) |=> (!id_valid && !ex_valid));

    a_r4_redirect: assert property (@(posedge clk) disable iff (rst)
        (ex_hit || mem_hit) |=> (fetch_pc == HANDLER_VEC));

    a_r6_mem_fault_no_commit: assert property (@(posedge clk) disable iff (rst)
        mem_hit |=> !rf_we);

    a_r7_record_held: assert property (@(posedge clk) disable iff (rst)
        trap_pending |=> $stable(epc));

    a_r8_empty_fault_ignored: assert property (@(posedge clk) disable iff (rst)
        (ex_fault && !ex_valid && !mem_hit) |=> (fetch_pc == $past(fetch_pc) + PC_W'(PC_STEP)));
endmodule

bind precise_trap_ctrl trap_ctrl_checker #(.HANDLER_VEC(HANDLER_VEC)) u_chk (
    .clk(clk), .rst(rst), .ex_fault(ex_fault), .ex_valid(ex_valid), .ex_pc(ex_pc),
    .mem_fault(mem_fault), .mem_valid(mem_valid), .mem_pc(mem_pc),
    .id_valid(id_valid), .rf_we(rf_we), .rf_pc(rf_pc), .fetch_pc(fetch_pc),
    .trap_pending(trap_pending), .epc(epc)
);

// File: tb/sim_precise_trap_ctrl.sv
`timescale 1ns/1ps
module sim_precise_trap_ctrl;
    import trap_pkg::*;

    localparam logic [PC_W-1:0] HV = PC_W'(32'h100);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [INSN_W-1:0] fetch_insn;
    logic ex_fault = 1'b0, mem_fault = 1'b0, trap_ack = 1'b0;
    logic [CAUSE_W-1:0] ex_cause = '0, mem_cause = '0;
    logic [PC_W-1:0] fetch_pc, ex_pc, mem_pc, rf_pc, epc;
    logic [INSN_W-1:0] ex_insn, rf_insn, einsn;
    logic ex_valid, mem_valid, mem_go, rf_we, trap_pending;
    logic [CAUSE_W-1:0] ecause;

    int checks = 0;
    int errors = 0;
    logic [PC_W-1:0] exp_q [$];

    always #10 clk = ~clk;

    function automatic logic [INSN_W-1:0] word_at(input logic [PC_W-1:0] pc);
        return {~pc[15:0], pc[15:0]} ^ INSN_W'(32'h0013_0000);
    endfunction

    assign fetch_insn = word_at(fetch_pc);

    precise_trap_ctrl #(.RESET_VEC('0), .HANDLER_VEC(HV)) u0 (
        .clk(clk), .rst(rst), .fetch_insn(fetch_insn),
        .ex_fault(ex_fault), .ex_cause(ex_cause),
        .mem_fault(mem_fault), .mem_cause(mem_cause), .trap_ack(trap_ack),
        .fetch_pc(fetch_pc), .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_insn(ex_insn),
        .mem_valid(mem_valid), .mem_pc(mem_pc), .mem_go(mem_go),
        .rf_we(rf_we), .rf_pc(rf_pc), .rf_insn(rf_insn),
        .trap_pending(trap_pending), .epc(epc), .einsn(einsn), .ecause(ecause)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_seq(input logic [PC_W-1:0] base, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(base + PC_W'(i * PC_STEP));
    endtask

    // monitor: every commit must match the next expected PC and word (R10, R2, R3)
    always @(negedge clk) begin
        if (!rst && rf_we) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected commit", rf_pc, '1);
            end else begin
                logic [PC_W-1:0] e;
                e = exp_q.pop_front();
                check("R10 commit pc (R2/R3 order)", rf_pc, e);
                check("R10 commit word", rf_insn, word_at(e));
            end
        end
    end

    task automatic wait_ex(input logic [PC_W-1:0] pc);
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (ex_valid && ex_pc == pc) return;
        end
        check("wait_ex timeout", 0, 1);
    endtask

    task automatic wait_mem(input logic [PC_W-1:0] pc);
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (mem_valid && mem_pc == pc) return;
        end
        check("wait_mem timeout", 0, 1);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 fetch_pc", fetch_pc, 0);
        check("R9 rf_we", rf_we, 0);
        check("R9 ex_valid", ex_valid, 0);
        check("R9 mem_valid", mem_valid, 0);
        check("R9 pending", trap_pending, 0);
        push_seq(0, 16);
        rst = 1'b0;

        // Scenario A: execute fault at 0x40
        wait_ex(PC_W'(32'h40));
        check("R1 older in mem", mem_pc, PC_W'(32'h3C));
        ex_fault = 1'b1; ex_cause = 4'd3;
        #1 check("R1 older mem_go", mem_go, 1);
        @(negedge clk);
        ex_fault = 1'b0;
        check("R4 redirect", fetch_pc, HV);
        check("R3 ex empty", ex_valid, 0);
        check("R1 older advanced", mem_valid ? 0 : 1, 1);
        check("R5 pending", trap_pending, 1);
        check("R5 epc", epc, PC_W'(32'h40));
        check("R5 einsn", einsn, word_at(PC_W'(32'h40)));
        check("R5 ecause", ecause, 3);
        push_seq(HV, 3);
        @(negedge clk);
        check("R2 faulter not in mem", mem_valid, 0);
        check("R4 sequential", fetch_pc, HV + 4);
        @(negedge clk);
        check("R7 epc held", epc, PC_W'(32'h40));
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
        check("R7 ack clears", trap_pending, 0);
        check("R7 epc kept", epc, PC_W'(32'h40));

        // Scenario B: memory and execute fault together
        wait_mem(HV + 12);
        check("R6 ex valid", ex_valid && ex_pc == HV + 16, 1);
        mem_fault = 1'b1; mem_cause = 4'd5;
        ex_fault = 1'b1;  ex_cause = 4'd3;
        #1 check("R6 mem_go blocked", mem_go, 0);
        @(negedge clk);
        mem_fault = 1'b0; ex_fault = 1'b0;
        check("R6 epc oldest", epc, HV + 12);
        check("R6 ecause oldest", ecause, 5);
        check("R6 einsn oldest", einsn, word_at(HV + 12));
        check("R4 redirect B", fetch_pc, HV);
        check("R6 mem empty", mem_valid, 0);
        push_seq(HV, 2);

        // Scenario C: fault while record pending
        wait_ex(HV + 8);
        ex_fault = 1'b1; ex_cause = 4'd7;
        @(negedge clk);
        ex_fault = 1'b0;
        check("R7 epc not overwritten", epc, HV + 12);
        check("R7 ecause not overwritten", ecause, 5);
        check("R4 redirect C", fetch_pc, HV);
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
        check("R7 cleared", trap_pending, 0);
        // Scenario D: fault with empty execute slot
        check("R8 ex empty", ex_valid, 0);
        ex_fault = 1'b1; ex_cause = 4'd9;
        @(negedge clk);
        ex_fault = 1'b0;
        check("R8 no record", trap_pending, 0);
        check("R8 fetch sequential", fetch_pc, HV + 8);
        push_seq(HV, 5);

        // Scenario E: new fault after ack is recorded
        wait_ex(HV + 20);
        ex_fault = 1'b1; ex_cause = 4'd2;
        @(negedge clk);
        ex_fault = 1'b0;
        check("R5 epc E", epc, HV + 20);
        check("R5 ecause E", ecause, 2);
        check("R5 pending E", trap_pending, 1);
        push_seq(HV, 20);
        repeat (12) @(negedge clk);
        check("R10 stream drained", exp_q.size() < 20 ? 1 : 0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule